// File: doc/BRIEF.md
# Dual-Supply Reset Pulse Generator

This block drives two active-low reset pins from three sources: a valid flag for the main supply, a valid flag for an auxiliary sensed supply, and an active-low manual reset request. Reset is held while any source is active. Once every source has been inactive long enough, reset stays asserted for a further `STRETCH_CYC` clock cycles before both pins are released. The stretch counter is held at zero whenever any source is active. A dip in either supply during a pending release therefore restarts the whole delay, counted from the moment of recovery.

The supply flags and the manual level pass through `SYNC_STAGES` flops (default 2) before the control logic uses them. A falling edge on the manual input is also captured asynchronously. A pulse too short to be seen by any clock edge still produces a complete reset, and this also debounces a pushbutton. The capture flop clears itself once its synchronized copy has been seen.

Each pin has its own active-low external pull input. The pin level is the AND of the shared internal drive and that pull, so pulling one pin low leaves the other untouched.

The control state machine has three states:
- HOLD: reset is asserted and the counter is zero.
- STRETCH: reset is asserted and the counter is advancing.
- RUN: reset is released.

Its transitions are:
- HOLD→STRETCH when no source is active.
- STRETCH→HOLD on any source.
- STRETCH→RUN when the counter reaches `STRETCH_CYC-1`.
- RUN→HOLD on any source.
- Reset of the block enters HOLD.

Top module: `dual_reset_stretcher`

## Requirements
- R1: A source is active when `main_ok`=0, `aux_ok`=0 or `man_req_n`=0. An active source sampled at rising edge k drives both pins low after edge k+2. The pins stay low while the source remains active.
- R2: If every source is sampled inactive from edge k onward, the pins go high after edge k+STRETCH_CYC+2 and not before.
- R3: Every reset pulse keeps the internal drive low for at least STRETCH_CYC cycles.
- R4: A source becoming active during the stretch period returns the counter to zero. Release then follows R2, counted from the recovery.
- R5: A low pulse on `man_req_n` may fall between two rising edges and be seen by none of them. Provided no other manual request occurred in the previous 8 cycles, the pins go low after the 3rd rising edge following the pulse. They go high again after the (STRETCH_CYC+6)th rising edge.
- R6: `rst_a_n` = drive AND `ext_a_n` and `rst_b_n` = drive AND `ext_b_n`. The two pins differ only when the two pull inputs differ.
- R7: While `rst_n` is low both pins are low. After `rst_n` rises with all sources inactive, the release follows R2, with the first edge after reset taken as k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| main_ok | input | 1 | Main supply valid flag (1 = valid) |
| aux_ok | input | 1 | Auxiliary sensed supply valid flag (1 = valid) |
| man_req_n | input | 1 | Manual reset request, active low, may be asynchronous |
| ext_a_n | input | 1 | External pull on pin A, active low |
| ext_b_n | input | 1 | External pull on pin B, active low |
| rst_a_n | output | 1 | Reset pin A, active low |
| rst_b_n | output | 1 | Reset pin B, active low |

## Verification
A counter that miscounts or fails to clear moves the release edge, and that error is visible on both pins within one stretch period of the last source clearing. The bench compares the pins every cycle against an arithmetic run-length model of the sampled sources. It sweeps a supply dip across every offset of the stretch window, so a restart that is missing or late shows up on that same trial.

A capture flop that is stuck or never clears shows either no reset after a sub-cycle manual pulse, or a reset that never releases. Both are detected within STRETCH_CYC+6 edges of the pulse.

// File: rtl/rpg_pkg.sv
package rpg_pkg;
    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_STRETCH = 2'd1,
        ST_RUN     = 2'd2
    } rpg_state_e;
endpackage

// File: rtl/rpg_sync.sv
module rpg_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/rpg_man_latch.sv
module rpg_man_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic man_req_n,
    input  logic seen,
    output logic cap
);
    logic clr_q;

    // clear request, registered so the asynchronous clear is glitch free
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clr_q <= 1'b1;
        else        clr_q <= seen;
    end

    // falling edge of the request sets the capture flop
    always_ff @(negedge man_req_n or posedge clr_q) begin
        if (clr_q) cap <= 1'b0;
        else       cap <= 1'b1;
    end
endmodule

// File: rtl/rpg_fsm.sv
module rpg_fsm
    import rpg_pkg::*;
#(
    parameter int STRETCH_CYC = 150,
    localparam int CW = $clog2(STRETCH_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          src_act,
    output logic          drive,
    output logic [CW-1:0] cnt
);
    rpg_state_e st, nxt;
    logic       cnt_done;

    assign cnt_done = (cnt == CW'(STRETCH_CYC - 1));

    always_comb begin
        nxt = st;
        unique case (st)
            ST_HOLD:    if (!src_act) nxt = ST_STRETCH;
            ST_STRETCH: begin
                if (src_act)       nxt = ST_HOLD;
                else if (cnt_done) nxt = ST_RUN;
            end
            ST_RUN:     if (src_act) nxt = ST_HOLD;
            default:    nxt = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_HOLD;
        else        st <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (st == ST_STRETCH && nxt == ST_STRETCH)
            cnt <= cnt + 1'b1;
        else
            cnt <= '0;
    end

    always_comb begin
        unique case (st)
            ST_RUN:  drive = 1'b1;
            default: drive = 1'b0;
        endcase
    end
endmodule

// File: rtl/dual_reset_stretcher.sv
module dual_reset_stretcher #(
    parameter int STRETCH_CYC = 150,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic main_ok,
    input  logic aux_ok,
    input  logic man_req_n,
    input  logic ext_a_n,
    input  logic ext_b_n,
    output logic rst_a_n,
    output logic rst_b_n
);
    localparam int CW   = $clog2(STRETCH_CYC + 1);
    localparam int NOUT = 2;

    logic [2:0]      lvl_s;
    logic            cap_raw, cap_s;
    logic            src_act;
    logic            drive;
    logic [CW-1:0]   stretch_cnt;
    logic [NOUT-1:0] ext_n, pin_n;

    // levels: {main, aux, manual}; reset to invalid supplies, idle manual
    rpg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_lvl_sync (
        .clk(clk), .rst_n(rst_n),
        .d({main_ok, aux_ok, man_req_n}),
        .q(lvl_s)
    );

    rpg_man_latch u_latch (
        .clk(clk), .rst_n(rst_n),
        .man_req_n(man_req_n), .seen(cap_s), .cap(cap_raw)
    );

    rpg_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_cap_sync (
        .clk(clk), .rst_n(rst_n), .d(cap_raw), .q(cap_s)
    );

    assign src_act = !lvl_s[2] || !lvl_s[1] || !lvl_s[0] || cap_s;

    rpg_fsm #(.STRETCH_CYC(STRETCH_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .src_act(src_act),
        .drive(drive), .cnt(stretch_cnt)
    );

    assign ext_n = {ext_b_n, ext_a_n};
    for (genvar g = 0; g < NOUT; g++) begin : g_pin
        assign pin_n[g] = drive & ext_n[g];
    end
    assign rst_a_n = pin_n[0];
    assign rst_b_n = pin_n[1];
endmodule

// File: rtl/rpg_chk.sv
module rpg_chk #(
    parameter int STRETCH_CYC = 150,
    localparam int CW = $clog2(STRETCH_CYC + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          src_act,
    input logic          drive,
    input logic [CW-1:0] cnt,
    input logic          rst_a_n,
    input logic          rst_b_n,
    input logic          ext_a_n,
    input logic          ext_b_n
);
    logic [CW:0] lowcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  lowcnt <= '0;
        else if (drive)              lowcnt <= '0;
        else if (lowcnt != '1)       lowcnt <= lowcnt + 1'b1;
    end

    AST_HOLD_ON_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        src_act |=> !drive); // R1

    AST_RELEASE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive) |-> !$past(src_act)); // R2

    AST_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive) |-> (lowcnt >= (CW+1)'(STRETCH_CYC))); // R3

    AST_STRETCH_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        src_act |=> (cnt == '0)); // R4

    AST_PINS_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_a_n != rst_b_n) |-> (ext_a_n != ext_b_n)); // R6
endmodule

bind dual_reset_stretcher rpg_chk #(.STRETCH_CYC(STRETCH_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .src_act(src_act), .drive(drive),
    .cnt(stretch_cnt), .rst_a_n(rst_a_n), .rst_b_n(rst_b_n),
    .ext_a_n(ext_a_n), .ext_b_n(ext_b_n)
);

// File: tb/sim_dual_reset_stretcher.sv
module sim_dual_reset_stretcher;
    localparam int CLK_PERIOD = 10;
    localparam int N = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic main_ok = 1'b1, aux_ok = 1'b1, man_req_n = 1'b1;
    logic ext_a_n = 1'b1, ext_b_n = 1'b1;
    logic rst_a_n, rst_b_n;

    int    vectors = 0;
    int    errors  = 0;
    bit    chk_en  = 1'b0;
    bit    mon_en  = 1'b0;
    string tag     = "R7";

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_reset_stretcher #(.STRETCH_CYC(N), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .main_ok(main_ok), .aux_ok(aux_ok),
        .man_req_n(man_req_n), .ext_a_n(ext_a_n), .ext_b_n(ext_b_n),
        .rst_a_n(rst_a_n), .rst_b_n(rst_b_n)
    );

    // run length of consecutive inactive samples, delayed by two edges
    int run, pl1, pl2;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run <= 0; pl1 <= 0; pl2 <= 0;
        end else begin
            if (!main_ok || !aux_ok || !man_req_n) run <= 0;
            else if (run < N + 5)                  run <= run + 1;
            pl1 <= run;
            pl2 <= pl1;
        end
    end

    task automatic check_bit(string t, logic act, logic exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", t, act, exp, $time);
        end
    endtask

    // reset-pulse width monitor at the pins
    int lowrun = 0;
    always @(negedge clk) begin
        if (mon_en) begin
            if (!rst_a_n) lowrun++;
            else if (lowrun > 0) begin
                vectors++;
                if (lowrun < N) begin
                    errors++;
                    $display("FAIL R3: actual width %0d expected >= %0d", lowrun, N);
                end
                lowrun = 0;
            end
        end
    end

    task automatic tick(int n);
        logic e;
        repeat (n) begin
            @(negedge clk);
            if (chk_en) begin
                e = (pl2 >= N + 1);
                check_bit(tag, rst_a_n, e & ext_a_n);
                check_bit(tag, rst_b_n, e & ext_b_n);
            end
        end
    endtask

    task automatic set_src(int s, logic v);
        case (s)
            0:       main_ok   = v;
            1:       aux_ok    = v;
            default: man_req_n = v;
        endcase
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL R2: watchdog expired, actual hung expected done");
        finish_run();
    end

    initial begin
        // R7: pins low during reset
        repeat (3) begin
            @(negedge clk);
            check_bit("R7", rst_a_n, 1'b0);
            check_bit("R7", rst_b_n, 1'b0);
        end
        rst_n = 1'b1;
        chk_en = 1'b1;
        tag = "R7";
        tick(N + 8);
        mon_en = 1'b1;

        // R1, R2: each source held for a range of widths
        tag = "R1,R2";
        for (int s = 0; s < 3; s++) begin
            for (int w = 1; w <= 8; w++) begin
                set_src(s, 1'b0);
                tick((s == 2 && w < 5) ? w + 4 : w);
                set_src(s, 1'b1);
                tick(N + 8);
            end
        end

        // R4: dip at every offset of the stretch window
        tag = "R4";
        for (int s = 0; s < 3; s++) begin
            for (int off = 0; off <= N + 1; off++) begin
                set_src(s, 1'b0);
                tick(5);
                set_src(s, 1'b1);
                tick(off);
                set_src(s, 1'b0);
                tick((s == 2) ? 5 : 1);
                set_src(s, 1'b1);
                tick(N + 8);
            end
        end

        // R6: independent external pulls with periodic brownouts
        mon_en = 1'b0;
        tag = "R6";
        for (int i = 0; i < 240; i++) begin
            ext_a_n = (i % 5) != 0;
            ext_b_n = (i % 3) != 0;
            main_ok = (i % 60) >= 4;
            tick(1);
        end
        ext_a_n = 1'b1;
        ext_b_n = 1'b1;
        main_ok = 1'b1;
        tick(N + 8);

        // R5: manual pulses seen by no clock edge
        chk_en = 1'b0;
        for (int d = 1; d <= 3; d++) begin
            @(negedge clk);
            #(d);
            man_req_n = 1'b0;
            #1;
            man_req_n = 1'b1;
            for (int j = 1; j <= N + 9; j++) begin
                logic e;
                @(negedge clk);
                e = !(j >= 3 && j <= N + 5);
                check_bit("R5", rst_a_n, e);
                check_bit("R5", rst_b_n, e);
            end
        end

        finish_run();
    end
endmodule